// File: doc/BRIEF.md
# Hierarchical Interrupt Status Encoder

This block gathers interrupt requests from three tiers, critical, main and peripheral, and folds them into one registered status word. For each tier the word holds an active flag and the index of the winning source. Priority is fixed within a tier: the lowest unmasked pending index wins. The main and peripheral tiers have mask registers in which a 1 disables a source. The critical tier has no mask.

Two slots carry traffic between tiers. Critical slot 2 stands for a high-class peripheral request, and main slot 4 stands for a low-class peripheral request. Peripheral source 0 is not a pin. It is the summary of a 32-bit DMA task sub-controller, which has its own pending register (set by request pulses, cleared by writing ones) and its own mask register. The block also reports the lowest pending DMA task.

Software writes the masks and the DMA clears through a single-cycle write port (`regWr`, `regAddr`, `regWrData`). Every register is visible on the outputs.

Top module: `irq_status_encoder`

## Requirements
- R1: Reset state:
  - status is 0, dmaPending is 0 and dmaIdx is 0.
  - mainMask reads 0x00010FFF and periMask reads 0x7FFFFC00.
  - dmaMask reads 0xFFFFFFFF.
- R2: status layout:
  - Critical flag in bit 10, with the index in bits [9:8].
  - Main flag in bit 21, with the index in bits [20:16].
  - Peripheral flag in bit 29, with the index in bits [28:24].
  - All other bits are 0, and a tier's index is 0 whenever its flag is 0.
  - status reflects the request inputs and register contents one clock edge after they are present.
- R3: Main tier:
  - Writing address 0 loads mainMask from bits [16:0]; bit 16-n set disables main source n.
  - The lowest enabled pending main index wins.
  - The flag is 0 when no main source is enabled and pending.
- R4: Peripheral tier:
  - Writing address 1 loads periMask from bits [31:10]; bit 31-n set disables peripheral source n.
  - The lowest enabled pending peripheral index wins.
- R5: Critical tier:
  - critReq bits 0, 1 and 3 are unmasked critical sources.
  - The lowest pending critical index wins.
- R6: Forwarding between tiers:
  - When the peripheral tier is active with index below 4, critical slot 2 is pending.
  - When it is active with index 4 or more, main slot 4 is pending, subject to main mask bit 12.
  - Inputs critReq[2], mainReq[4] and periReq[0] are ignored.
- R7: DMA pending register:
  - A 1 on dmaReq[n] sets pending bit n one edge later.
  - Pending bits hold until a write to address 2 with data bit n = 1 clears bit n.
  - Zero data bits leave pending bits unchanged.
- R8: A DMA request and a clear of the same bit in the same cycle leave the bit set.
- R9: DMA cascade:
  - Writing address 3 loads dmaMask; bit n set disables DMA task n.
  - Peripheral source 0 is pending when any enabled DMA task is pending.
  - Peripheral source 0 is still gated by periMask bit 31.
- R10: dmaIdx:
  - dmaIdx is the lowest set dmaPending bit, taken one edge after the pending value, regardless of dmaMask.
  - dmaIdx is 0 when nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 main mask, 1 peripheral mask, 2 DMA clear, 3 DMA mask |
| regWrData | input | 32 | Write data |
| critReq | input | 4 | Critical requests (bit 2 ignored) |
| mainReq | input | 17 | Main requests (bit 4 ignored) |
| periReq | input | 22 | Peripheral requests (bit 0 ignored) |
| dmaReq | input | 32 | DMA task request pulses |
| status | output | 32 | Registered encoded status word |
| dmaIdx | output | 5 | Lowest pending DMA task |
| mainMask | output | 32 | Main mask readback |
| periMask | output | 32 | Peripheral mask readback |
| dmaPending | output | 32 | DMA pending register |
| dmaMask | output | 32 | DMA mask register |

## Verification
A wrong mask bit or a misplaced mask bit position shows up within one edge as a shifted winner index in status. A lost or stuck DMA pending bit shows up two edges after the request or clear: first on dmaPending, then on dmaIdx and the peripheral field of status. Broken forwarding appears in the same status update as the peripheral winner, as a missing or wrong critical slot 2 or main slot 4. The sweeps walk every index through every tier, and every mask prefix, so an off-by-one in the bit mapping changes at least one expected word.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int CRIT_IDX_W = 2;
  localparam int MAIN_IDX_W = 5;
  localparam int PERI_IDX_W = 5;
  localparam int DMA_IDX_W  = 5;
  localparam int REG_W      = 32;

  localparam int CRIT_FLAG_BIT = 10;
  localparam int CRIT_IDX_LSB  = 8;
  localparam int MAIN_FLAG_BIT = 21;
  localparam int MAIN_IDX_LSB  = 16;
  localparam int PERI_FLAG_BIT = 29;
  localparam int PERI_IDX_LSB  = 24;

  localparam logic [REG_W-1:0] MAIN_MASK_RST = 32'h0001_0FFF;
  localparam logic [REG_W-1:0] PERI_MASK_RST = 32'h7FFF_FC00;

  typedef enum logic [1:0] {
    ADDR_MAIN_MASK = 2'd0,
    ADDR_PERI_MASK = 2'd1,
    ADDR_DMA_CLEAR = 2'd2,
    ADDR_DMA_MASK  = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic wrMainMask;
    logic wrPeriMask;
    logic clrDmaPend;
    logic wrDmaMask;
  } regStrobe_t;
endpackage

// File: rtl/irq_enc_prio.sv
module irq_enc_prio #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx
);
  // lowest set index wins; zero when nothing set
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/irq_enc_ctrl.sv
module irq_enc_ctrl
  import irq_enc_pkg::*;
(
  input  logic       regWr,
  input  logic [1:0] regAddr,
  output regStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (regWr) begin
      case (regAddr_e'(regAddr))
        ADDR_MAIN_MASK: strobe.wrMainMask = 1'b1;
        ADDR_PERI_MASK: strobe.wrPeriMask = 1'b1;
        ADDR_DMA_CLEAR: strobe.clrDmaPend = 1'b1;
        ADDR_DMA_MASK:  strobe.wrDmaMask  = 1'b1;
        default:        strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_enc_dpath.sv
module irq_enc_dpath
  import irq_enc_pkg::*;
#(
  parameter int CRIT_N    = 4,
  parameter int MAIN_N    = 17,
  parameter int PERI_N    = 22,
  parameter int DMA_N     = 32,
  parameter int PERI_HI_N = 4,
  parameter int CRIT_FWD  = 2,
  parameter int MAIN_FWD  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrobe_t           strobe,
  input  logic [REG_W-1:0]     wrData,
  input  logic [CRIT_N-1:0]    critReq,
  input  logic [MAIN_N-1:0]    mainReq,
  input  logic [PERI_N-1:0]    periReq,
  input  logic [DMA_N-1:0]     dmaReq,
  output logic [REG_W-1:0]     status,
  output logic [DMA_IDX_W-1:0] dmaIdx,
  output logic [REG_W-1:0]     mainMask,
  output logic [REG_W-1:0]     periMask,
  output logic [DMA_N-1:0]     dmaPending,
  output logic [DMA_N-1:0]     dmaMask
);
  localparam int PERI_LSB = REG_W - PERI_N;
  localparam logic [PERI_IDX_W-1:0] PERI_HI_IDX = PERI_IDX_W'(PERI_HI_N);

  logic [MAIN_N-1:0]    mainMaskQ;
  logic [PERI_N-1:0]    periMaskQ;
  logic [DMA_N-1:0]     dmaPendNext;
  logic [DMA_IDX_W-1:0] dmaIdxNext;
  logic [PERI_N-1:0]    periRaw, periLive;
  logic [MAIN_N-1:0]    mainRaw, mainLive;
  logic [CRIT_N-1:0]    critRaw;
  logic [PERI_IDX_W-1:0] periIdx;
  logic [MAIN_IDX_W-1:0] mainIdx;
  logic [CRIT_IDX_W-1:0] critIdx;
  logic                 periAny, mainAny, critAny, dmaCascade;
  logic [REG_W-1:0]     statusNext;
  logic                 unusedBits;

  assign unusedBits = ^{periReq[0], critReq[CRIT_FWD], mainReq[MAIN_FWD]};

  // DMA pending: a request in the same cycle as a clear keeps the bit set
  assign dmaPendNext = (dmaPending & ~(strobe.clrDmaPend ? wrData[DMA_N-1:0] : '0)) | dmaReq;
  assign dmaCascade  = |(dmaPending & ~dmaMask);

  irq_enc_prio #(.N(DMA_N), .W(DMA_IDX_W)) u_dmaEnc (.req(dmaPending), .idx(dmaIdxNext));

  // peripheral tier, source 0 is the DMA summary
  always_comb begin
    periRaw    = periReq;
    periRaw[0] = dmaCascade;
  end

  for (genvar n = 0; n < PERI_N; n++) begin : g_periLive
    assign periLive[n] = periRaw[n] & ~periMaskQ[PERI_N-1-n];
  end
  assign periAny = |periLive;
  irq_enc_prio #(.N(PERI_N), .W(PERI_IDX_W)) u_periEnc (.req(periLive), .idx(periIdx));

  // forwarding of the peripheral winner into critical and main slots
  always_comb begin
    critRaw           = critReq;
    critRaw[CRIT_FWD] = periAny && (periIdx < PERI_HI_IDX);
    mainRaw           = mainReq;
    mainRaw[MAIN_FWD] = periAny && (periIdx >= PERI_HI_IDX);
  end

  for (genvar n = 0; n < MAIN_N; n++) begin : g_mainLive
    assign mainLive[n] = mainRaw[n] & ~mainMaskQ[MAIN_N-1-n];
  end
  assign mainAny = |mainLive;
  irq_enc_prio #(.N(MAIN_N), .W(MAIN_IDX_W)) u_mainEnc (.req(mainLive), .idx(mainIdx));

  assign critAny = |critRaw;
  irq_enc_prio #(.N(CRIT_N), .W(CRIT_IDX_W)) u_critEnc (.req(critRaw), .idx(critIdx));

  always_comb begin
    statusNext = '0;
    statusNext[CRIT_FLAG_BIT] = critAny;
    statusNext[CRIT_IDX_LSB +: CRIT_IDX_W] = critIdx;
    statusNext[MAIN_FLAG_BIT] = mainAny;
    statusNext[MAIN_IDX_LSB +: MAIN_IDX_W] = mainIdx;
    statusNext[PERI_FLAG_BIT] = periAny;
    statusNext[PERI_IDX_LSB +: PERI_IDX_W] = periIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainMaskQ  <= MAIN_MASK_RST[MAIN_N-1:0];
      periMaskQ  <= PERI_MASK_RST[REG_W-1:PERI_LSB];
      dmaMask    <= '1;
      dmaPending <= '0;
      status     <= '0;
      dmaIdx     <= '0;
    end else begin
      if (strobe.wrMainMask) mainMaskQ <= wrData[MAIN_N-1:0];
      if (strobe.wrPeriMask) periMaskQ <= wrData[REG_W-1:PERI_LSB];
      if (strobe.wrDmaMask)  dmaMask   <= wrData[DMA_N-1:0];
      dmaPending <= dmaPendNext;
      status     <= statusNext;
      dmaIdx     <= dmaIdxNext;
    end
  end

  assign mainMask = {{(REG_W-MAIN_N){1'b0}}, mainMaskQ};
  assign periMask = {periMaskQ, {PERI_LSB{1'b0}}};

  // R2: a tier with a clear flag reports index zero
  p_idle_index_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!status[CRIT_FLAG_BIT] |-> status[CRIT_IDX_LSB +: CRIT_IDX_W] == '0) and
    (!status[MAIN_FLAG_BIT] |-> status[MAIN_IDX_LSB +: MAIN_IDX_W] == '0) and
    (!status[PERI_FLAG_BIT] |-> status[PERI_IDX_LSB +: PERI_IDX_W] == '0));

  p_hi_forward_r6: assert property (@(posedge clk) disable iff (!rstN)
    (status[CRIT_FLAG_BIT] && status[CRIT_IDX_LSB +: CRIT_IDX_W] == CRIT_IDX_W'(CRIT_FWD))
    |-> (status[PERI_FLAG_BIT] && status[PERI_IDX_LSB +: PERI_IDX_W] < PERI_HI_IDX));

  p_lo_forward_r6: assert property (@(posedge clk) disable iff (!rstN)
    (status[MAIN_FLAG_BIT] && status[MAIN_IDX_LSB +: MAIN_IDX_W] == MAIN_IDX_W'(MAIN_FWD))
    |-> (status[PERI_FLAG_BIT] && status[PERI_IDX_LSB +: PERI_IDX_W] >= PERI_HI_IDX));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrDmaPend |=> ((dmaPending & $past(wrData[DMA_N-1:0] & ~dmaReq)) == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrDmaPend |=> (($past(dmaPending) & ~dmaPending) == '0));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaReq) |=> ((dmaPending & $past(dmaReq)) == $past(dmaReq)));

  p_dma_cascade_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dmaCascade && !periMaskQ[PERI_N-1])
    |=> (status[PERI_FLAG_BIT] && status[PERI_IDX_LSB +: PERI_IDX_W] == '0));

  p_dma_lowest_r10: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaPending) |=> ((($past(dmaPending) >> dmaIdx) & DMA_N'(1)) != '0) &&
                      (($past(dmaPending) << (DMA_N - int'(dmaIdx))) == '0));
endmodule

// File: rtl/irq_status_encoder.sv
module irq_status_encoder
  import irq_enc_pkg::*;
#(
  parameter int CRIT_N    = 4,
  parameter int MAIN_N    = 17,
  parameter int PERI_N    = 22,
  parameter int DMA_N     = 32,
  parameter int PERI_HI_N = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWr,
  input  logic [1:0]           regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [CRIT_N-1:0]    critReq,
  input  logic [MAIN_N-1:0]    mainReq,
  input  logic [PERI_N-1:0]    periReq,
  input  logic [DMA_N-1:0]     dmaReq,
  output logic [REG_W-1:0]     status,
  output logic [DMA_IDX_W-1:0] dmaIdx,
  output logic [REG_W-1:0]     mainMask,
  output logic [REG_W-1:0]     periMask,
  output logic [DMA_N-1:0]     dmaPending,
  output logic [DMA_N-1:0]     dmaMask
);
  regStrobe_t strobe;

  irq_enc_ctrl u_ctrl (
    .regWr  (regWr),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  irq_enc_dpath #(
    .CRIT_N(CRIT_N), .MAIN_N(MAIN_N), .PERI_N(PERI_N),
    .DMA_N(DMA_N), .PERI_HI_N(PERI_HI_N), .CRIT_FWD(2), .MAIN_FWD(4)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .critReq   (critReq),
    .mainReq   (mainReq),
    .periReq   (periReq),
    .dmaReq    (dmaReq),
    .status    (status),
    .dmaIdx    (dmaIdx),
    .mainMask  (mainMask),
    .periMask  (periMask),
    .dmaPending(dmaPending),
    .dmaMask   (dmaMask)
  );
endmodule

// File: tb/irq_status_encoder_bench.sv
`timescale 1ns/1ps
module irq_status_encoder_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  critReq = '0;
  logic [16:0] mainReq = '0;
  logic [21:0] periReq = '0;
  logic [31:0] dmaReq = '0;
  logic [31:0] status, mainMask, periMask, dmaPending, dmaMask;
  logic [4:0]  dmaIdx;

  logic [16:0] shMain = 17'h10FFF;
  logic [31:0] shPeri = 32'h7FFF_FC00;
  logic [31:0] shDmaMask = 32'hFFFF_FFFF;
  logic [31:0] shPend = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_status_encoder u_irq_status_encoder (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWrData(wrData),
    .critReq(critReq), .mainReq(mainReq), .periReq(periReq), .dmaReq(dmaReq),
    .status(status), .dmaIdx(dmaIdx), .mainMask(mainMask), .periMask(periMask),
    .dmaPending(dmaPending), .dmaMask(dmaMask)
  );

  function automatic logic [31:0] expStatus();
    logic [21:0] p; logic [3:0] c; logic [16:0] m;
    logic pa, ca, ma; int pi, ci, mi; logic [31:0] s;
    p = periReq; p[0] = |(shPend & ~shDmaMask);
    pa = 0; pi = 0;
    for (int n = 21; n >= 0; n--) if (p[n] && !shPeri[31-n]) begin pa = 1; pi = n; end
    c = critReq; c[2] = pa && (pi < 4);
    m = mainReq; m[4] = pa && (pi >= 4);
    ca = 0; ci = 0;
    for (int n = 3; n >= 0; n--) if (c[n]) begin ca = 1; ci = n; end
    ma = 0; mi = 0;
    for (int n = 16; n >= 0; n--) if (m[n] && !shMain[16-n]) begin ma = 1; mi = n; end
    s = '0;
    s[10] = ca; s[9:8] = ci[1:0];
    s[21] = ma; s[20:16] = mi[4:0];
    s[29] = pa; s[28:24] = pi[4:0];
    return s;
  endfunction

  function automatic logic [31:0] expDmaIdx();
    logic [31:0] r = '0;
    for (int k = 31; k >= 0; k--) if (shPend[k]) r = k;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chkStatus(input string tag);
    check(tag, status, expStatus());
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; wrData = '0;
    case (a)
      2'd0: shMain = d[16:0];
      2'd1: shPeri = d & 32'hFFFF_FC00;
      2'd2: shPend = shPend & ~d;
      default: shDmaMask = d;
    endcase
  endtask

  task automatic dmaPulse(input logic [31:0] v);
    dmaReq = v;
    @(negedge clk);
    dmaReq = '0;
    shPend = shPend | v;
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_1234;
    repeat (3) @(negedge clk);
    check("R1 status in reset", status, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 status", status, 32'h0);
    check("R1 mainMask", mainMask, 32'h0001_0FFF);
    check("R1 periMask", periMask, 32'h7FFF_FC00);
    check("R1 dmaMask", dmaMask, 32'hFFFF_FFFF);
    check("R1 dmaPending", dmaPending, 32'h0);
    check("R1 dmaIdx", {27'b0, dmaIdx}, 32'h0);
    mainReq = '1; periReq = '1;
    settle();
    check("R1 reset masks leave main 1", status, 32'h0021_0000);
    mainReq = '0; periReq = '0;
    settle();

    // R2 one-edge latency
    mainReq = 17'h4;
    @(negedge clk);
    check("R2 latency set", status, 32'h0022_0000);
    mainReq = '0;
    @(negedge clk);
    check("R2 latency clear", status, 32'h0);

    // R3 main sweeps
    regWrite(2'd0, 32'h0);
    check("R3 mask readback", mainMask, 32'h0);
    for (int n = 0; n < 17; n++) begin
      mainReq = 17'h1FFFF << n;
      settle();
      chkStatus($sformatf("R3 req sweep n=%0d", n));
    end
    mainReq = '1;
    for (int n = 0; n <= 17; n++) begin
      logic [31:0] mk = '0;
      for (int k = 0; k < n; k++) mk[16-k] = 1'b1;
      regWrite(2'd0, mk);
      settle();
      chkStatus($sformatf("R3 mask sweep n=%0d", n));
    end
    regWrite(2'd0, 32'h0);
    mainReq = '0;

    // R5 critical sweep
    for (int v = 0; v < 16; v++) begin
      critReq = v[3:0];
      settle();
      chkStatus($sformatf("R5 crit v=%0d", v));
    end
    critReq = '0;

    // R4 peripheral sweeps
    regWrite(2'd1, 32'h0);
    for (int n = 1; n < 22; n++) begin
      periReq = 22'h3FFFFF << n;
      settle();
      chkStatus($sformatf("R4 req sweep n=%0d", n));
    end
    periReq = '1;
    for (int n = 0; n <= 22; n++) begin
      logic [31:0] mk = '0;
      for (int k = 0; k < n; k++) mk[31-k] = 1'b1;
      regWrite(2'd1, mk);
      settle();
      chkStatus($sformatf("R4 mask sweep n=%0d", n));
    end
    regWrite(2'd1, 32'h0);

    // R6 forwarding computed arithmetically
    for (int n = 1; n < 22; n++) begin
      periReq = 22'h1 << n;
      settle();
      check($sformatf("R6 crit slot n=%0d", n), {29'b0, status[10:8]}, (n < 4) ? 32'h6 : 32'h0);
      check($sformatf("R6 main slot n=%0d", n), {26'b0, status[21:16]}, (n >= 4) ? 32'h24 : 32'h0);
    end
    regWrite(2'd0, 32'h1000);
    periReq = 22'h1 << 7;
    settle();
    check("R6 main slot masked", status, 32'h2700_0000);
    regWrite(2'd0, 32'h0);
    periReq = 22'h1; critReq = 4'b0100; mainReq = 17'h10;
    settle();
    check("R6 ignored inputs", status, 32'h0);
    critReq = '0; mainReq = '0; periReq = '0;

    // R7 / R10 DMA pending and lowest index
    regWrite(2'd3, 32'h0);
    for (int k = 31; k >= 0; k -= 3) begin
      dmaPulse(32'h1 << k);
      settle();
      check($sformatf("R7 pending k=%0d", k), dmaPending, shPend);
      check($sformatf("R10 dmaIdx k=%0d", k), {27'b0, dmaIdx}, expDmaIdx());
      chkStatus($sformatf("R9 cascade k=%0d", k));
    end
    regWrite(2'd2, 32'h0);
    settle();
    check("R7 zero write keeps", dmaPending, shPend);
    regWrite(2'd2, 32'h0000_00FF);
    settle();
    check("R7 clear low byte", dmaPending, shPend);
    check("R10 after clear", {27'b0, dmaIdx}, expDmaIdx());
    for (int k = 8; k < 32; k++) begin
      regWrite(2'd2, 32'h1 << k);
      settle();
      check($sformatf("R10 walk k=%0d", k), {27'b0, dmaIdx}, expDmaIdx());
      chkStatus($sformatf("R7 status walk k=%0d", k));
    end
    check("R7 all cleared", dmaPending, 32'h0);

    // R8 set wins over clear
    dmaReq = 32'h0000_1200; regAddr = 2'd2; wrData = 32'h0000_1208; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; dmaReq = '0; wrData = '0;
    shPend = (shPend & ~32'h0000_1208) | 32'h0000_1200;
    check("R8 same cycle", dmaPending, 32'h0000_1200);
    settle();
    check("R8 still set", dmaPending, 32'h0000_1200);

    // R9 gating
    regWrite(2'd3, 32'h0000_1200);
    settle();
    chkStatus("R9 all dma masked");
    check("R9 flag low", {31'b0, status[29]}, 32'h0);
    check("R10 ignores mask", {27'b0, dmaIdx}, 32'd9);
    regWrite(2'd3, 32'h0000_0200);
    settle();
    check("R9 one live task", status, 32'h2000_0600);
    periReq = 22'h208;
    settle();
    chkStatus("R9 dma beats other periph");
    regWrite(2'd1, 32'h8000_0000);
    settle();
    chkStatus("R9 periph bit 31 gates");
    periReq = '0;
    settle();
    check("R9 gated flag low", status, 32'h0);
    regWrite(2'd1, 32'h0);

    // mixed patterns
    for (int it = 0; it < 200; it++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      critReq = lfsr[3:0] & {4{lfsr[30]}};
      mainReq = lfsr[20:4];
      periReq = {lfsr[31:11], 1'b0} & {22{lfsr[7]}};
      if (lfsr[9:8] == 2'b00) regWrite(2'd0, {15'b0, lfsr[16:0] & lfsr[27:11]});
      if (lfsr[9:8] == 2'b01) regWrite(2'd1, lfsr & (lfsr << 3));
      if (lfsr[9:8] == 2'b10) dmaPulse(lfsr & (lfsr >> 7));
      if (lfsr[9:8] == 2'b11) regWrite(2'd2, lfsr);
      settle();
      chkStatus($sformatf("R2 mixed it=%0d", it));
      check($sformatf("R7 mixed it=%0d", it), dmaPending, shPend);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R2 act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule